// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for serial TDM traffic. It receives several bit-serial input streams that all share one bit clock and one frame pulse. Each frame carries a fixed number of 8-bit channels, sent MSB first. Every completed input byte is stored in a two-bank data memory, and the bank is chosen by frame parity. Each output stream and channel has its own connection entry. That entry decides what leaves in the slot: a byte switched from any input stream and channel, a fixed message byte held in the entry, all ones, or nothing at all (high impedance).

A single-cycle write port loads connection entries and a global rate setting into a shadow copy. The shadow copy becomes live only at a frame boundary, so every frame is sent under one consistent configuration. The rate setting selects how many output streams are active. Each switched entry also selects one of two delays: a fixed one-frame delay that keeps frame integrity, or a minimum-latency mode that sends a byte in the same frame whenever the source channel has already been fully received.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted, and afterwards until written entries take effect, every `sto_oe` bit and every `sto` bit is 0. Reset puts every entry in the high-impedance state.
- R2: A connection entry is 12 bits. Bit 11 selects high impedance, bit 10 forces the slot high, bit 9 selects a message byte and bit 8 selects minimum latency. With bits 11:8 all zero, the slot carries the byte received on input stream `e[6:5]`, channel `e[4:0]`, in the previous frame.
- R3: With bit 8 set, the source byte is taken from the current frame when the source channel number is strictly less than the output channel number, and from the previous frame otherwise. This includes the case where the source channel is the one that finished in the cycle just before the slot.
- R4: With bit 9 set and bits 11:10 clear, the slot carries `e[7:0]`.
- R5: With bit 10 set and bit 11 clear, the slot carries 8'hFF, whatever bits 9:0 hold.
- R6: With bit 11 set, `sto_oe` is 0 for the whole slot and `sto` is 0, whatever bits 10:0 hold.
- R7: `ode_i[s]` low forces `sto_oe[s]` and `sto[s]` low in the same cycle. No other slot state is changed by it.
- R8: A write with `wr_addr[7]`=1 sets the rate field from `wr_data[1:0]`. Rate 0 activates all four streams, rate 1 activates streams 0 to 1, and rates 2 and 3 activate stream 0 only. An inactive stream has `sto_oe` and `sto` low.
- R9: `fp_i` is high for the one cycle just before bit 7 of channel 0. Channel c of a frame occupies cycles 8c to 8c+7 after the pulse, MSB first, on both inputs and outputs.
- R10: A write with `wr_addr[7]`=0 goes to entry `wr_addr[6:0]` = {stream, channel}. Writes take effect at the next frame boundary. A write made in the last cycle of a frame takes effect one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Frame pulse, one cycle before channel 0 |
| sti | input | NSTR | Serial input streams |
| ode_i | input | NSTR | Per-stream output drive enable |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Bit 7 selects the rate register; bits 6:0 select an entry |
| wr_data | input | 12 | Entry value or rate value |
| sto | output | NSTR | Serial output streams |
| sto_oe | output | NSTR | Per-stream tri-state control, high to drive |

## Verification
Two functions meet in the same clock edge in this block. In minimum-latency mode, the byte a slot needs can be the input byte that completes on the very edge where the slot's output byte is loaded. In fixed-delay mode, channel 0 of a new frame can read the last channel of the frame that closes on that same edge. The bench provokes both by programming entries whose source channel is one below the output channel, and entries whose source is the last channel, read by every output channel including channel 0. A behavioural model tracks received bytes by frame number and names the frame each slot must draw from. It compares both output pins every cycle, so a stale byte read from memory instead of the byte that just arrived shows up as a bit mismatch.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSTR = 4,
  parameter int NCH  = 32,
  localparam int SW   = $clog2(NSTR),
  localparam int CW   = $clog2(NCH),
  localparam int IW   = SW + CW,
  localparam int AW   = IW + 1,
  localparam int EW   = 12,
  localparam int FW   = $clog2(NCH * 8),
  localparam int LAST = NCH * 8 - 1,
  localparam int NE   = NSTR * NCH,
  localparam int NA1  = (NSTR / 2 > 0) ? NSTR / 2 : 1,
  localparam int NA2  = (NSTR / 4 > 0) ? NSTR / 4 : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  input  logic [NSTR-1:0] sti,
  input  logic [NSTR-1:0] ode_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [EW-1:0]   wr_data,
  output logic [NSTR-1:0] sto,
  output logic [NSTR-1:0] sto_oe
);

  localparam logic [EW-1:0] ENT_RST = 12'h800;

  logic [FW-1:0] cnt;
  logic          par;
  logic [1:0]    rate_sh, rate_act;
  logic [EW-1:0] cm_sh  [NE];
  logic [EW-1:0] cm_act [NE];
  logic [7:0]    dm [2][NSTR][NCH];
  logic [7:0]    ish [NSTR];

  wire          bnd   = fp_i || (cnt == FW'(LAST));
  wire          bdone = (cnt[2:0] == 3'd7);
  wire          ld    = bnd || bdone;
  wire [CW-1:0] wch   = cnt[FW-1:3];
  wire [CW-1:0] nch   = bnd ? '0 : wch + 1'b1;
  wire          pn    = bnd ? ~par : par;
  wire [1:0]    rsel  = bnd ? rate_sh : rate_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      par      <= 1'b0;
      rate_sh  <= 2'd0;
      rate_act <= 2'd0;
      for (int i = 0; i < NE; i++) begin
        cm_sh[i]  <= ENT_RST;
        cm_act[i] <= ENT_RST;
      end
    end else begin
      cnt <= bnd ? '0 : cnt + 1'b1;
      if (bnd) begin
        par      <= ~par;
        rate_act <= rate_sh;
        cm_act   <= cm_sh;
      end
      if (wr_en) begin
        if (wr_addr[IW]) rate_sh <= wr_data[1:0];
        else             cm_sh[wr_addr[IW-1:0]] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTR; s++) begin
        ish[s] <= '0;
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < NCH; c++)
            dm[b][s][c] <= '0;
      end
    end else begin
      for (int s = 0; s < NSTR; s++) begin
        ish[s] <= {ish[s][6:0], sti[s]};
        if (bdone) dm[par][s][wch] <= {ish[s][6:0], sti[s]};
      end
    end
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_out
    localparam logic [SW-1:0] SI = SW'(s);
    logic [EW-1:0] e;
    logic [SW-1:0] src_s;
    logic [CW-1:0] src_c;
    logic          rb, fwd, act_n;
    logic [7:0]    sw_byte, nbyte, osh;
    logic          oe_q;

    assign e       = bnd ? cm_sh[{SI, nch}] : cm_act[{SI, nch}];
    assign src_s   = e[IW-1:CW];
    assign src_c   = e[CW-1:0];
    assign rb      = (e[8] && (src_c < nch)) ? pn : ~pn;
    assign fwd     = bdone && (rb == par) && (src_c == wch);
    assign sw_byte = fwd ? {ish[src_s][6:0], sti[src_s]} : dm[rb][src_s][src_c];
    assign nbyte   = e[10] ? 8'hFF : (e[9] ? e[7:0] : sw_byte);
    assign act_n   = (rsel == 2'd0) ? 1'b1 : (rsel == 2'd1) ? (s < NA1) : (s < NA2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        osh  <= '0;
        oe_q <= 1'b0;
      end else if (ld) begin
        osh  <= nbyte;
        oe_q <= ~e[11] & act_n;
      end else begin
        osh  <= {osh[6:0], 1'b0};
      end
    end

    assign sto_oe[s] = oe_q & ode_i[s];
    assign sto[s]    = oe_q & ode_i[s] & osh[7];
  end

endmodule

module tsi_switch_chk #(
  parameter int NSTR = 4,
  parameter int FW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fp_i,
  input logic            bnd,
  input logic [FW-1:0]   cnt,
  input logic [1:0]      rate_act,
  input logic [NSTR-1:0] ode_i,
  input logic [NSTR-1:0] sto_oe
);
  localparam int NA1 = (NSTR / 2 > 0) ? NSTR / 2 : 1;
  localparam int NA2 = (NSTR / 4 > 0) ? NSTR / 4 : 1;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sto_oe == '0));

  // R9
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (cnt == '0));

  // R10
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(rate_act));

  // R6
  slot_oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && cnt[2:0] != 3'd7) ##1 $stable(ode_i) |-> $stable(sto_oe));

  for (genvar s = 0; s < NSTR; s++) begin : g_rate
    wire act = (rate_act == 2'd0) ? 1'b1 : (rate_act == 2'd1) ? (s < NA1) : (s < NA2);
    // R8
    idle_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !sto_oe[s]);
  end
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .bnd(bnd), .cnt(cnt),
  .rate_act(rate_act), .ode_i(ode_i), .sto_oe(sto_oe)
);

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
  localparam int CLK_NS = 10;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam int LAST = NC * 8 - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp = 1'b0;
  logic [NS-1:0] sti = '0;
  logic [NS-1:0] ode = '1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [NS-1:0] sto, sto_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0]  inb [4][NS][NC];
  logic [11:0] sh_cfg [NS*NC];
  logic [11:0] act_cfg [NS*NC];
  int rate_sh_m = 0;
  int rate_act_m = 0;
  logic [19:0] wq[$];

  always #(CLK_NS/2) clk = ~clk;

  tsi_switch dut_i (
    .clk(clk), .rst_n(rst_n), .fp_i(fp), .sti(sti), .ode_i(ode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sto(sto), .sto_oe(sto_oe)
  );

  function automatic logic [7:0] gen(int f, int s, int c);
    return 8'((f * 53 + s * 89 + c * 29 + 17) & 255);
  endfunction

  function automatic logic [11:0] cfg(int p, int s, int c);
    int k = (s * 3 + c + p) % 8;
    case (k)
      0: return {4'b0000, 1'b0, 2'((s + 1) % 4), 5'(NC - 1 - c)};
      1: return {4'b0001, 1'b0, 2'(s), 5'((c + NC - 1) % NC)};
      2: return {4'b0001, 1'b0, 2'((s + 2) % 4), 5'(c)};
      3: return {4'b0010, 8'(c * 5 + s + p)};
      4: return {4'b0110, 8'h12};
      5: return {4'b1100, 8'h00};
      6: return {4'b0001, 1'b0, 2'(s), 5'(NC - 1)};
      default: return {4'b0000, 1'b0, 2'((s + 3) % 4), 5'(NC - 1)};
    endcase
  endfunction

  task automatic note(bit ok, string tag, int s, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s stream %0d {oe,d} actual=%b expected=%b", tag, s, act, exp);
    end
  endtask

  task automatic compare(int f, int pos);
    int c = pos / 8;
    int b = 7 - pos % 8;
    int nact = (rate_act_m == 0) ? 4 : (rate_act_m == 1) ? 2 : 1;
    for (int s = 0; s < NS; s++) begin
      logic [11:0] e = act_cfg[s * NC + c];
      logic [7:0] byt;
      logic eoe, ed;
      string tag;
      int sc = int'(e[4:0]);
      int ss = int'(e[6:5]);
      int fr = (e[8] && sc < c) ? f : f - 1;
      byt = e[10] ? 8'hFF : e[9] ? e[7:0] : (fr < 0 ? 8'h00 : inb[fr % 4][ss][sc]);
      eoe = (s < nact) && ode[s] && !e[11];
      ed  = eoe && byt[b];
      if (f == 0)                       tag = "R1";
      else if (f == 6 && s == 0 && c == 0) tag = "R10";
      else if (s >= nact)               tag = "R8";
      else if (!ode[s])                 tag = "R7";
      else if (e[11])                   tag = "R6";
      else if (e[10])                   tag = "R5";
      else if (e[9])                    tag = "R4";
      else if (c == 0)                  tag = "R9";
      else if (e[8])                    tag = "R3";
      else                              tag = "R2";
      note(sto_oe[s] == eoe && sto[s] == ed, tag, s, {sto_oe[s], sto[s]}, {eoe, ed});
    end
  endtask

  initial begin
    for (int i = 0; i < NS * NC; i++) begin
      sh_cfg[i] = 12'h800;
      act_cfg[i] = 12'h800;
    end
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NC; c++)
          inb[f][s][c] = 8'h00;

    repeat (3) begin
      @(negedge clk);
      note(sto_oe == '0 && sto == '0, "R1", 0, {|sto_oe, |sto}, 2'b00);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      #1;
      note(sto_oe == '0 && sto == '0, "R1", 0, {|sto_oe, |sto}, 2'b00);
    end
    @(negedge clk);
    fp = 1'b1;
    #1;
    note(sto_oe == '0 && sto == '0, "R1", 0, {|sto_oe, |sto}, 2'b00);

    for (int f = 0; f <= 10; f++) begin
      for (int pos = 0; pos <= LAST; pos++) begin
        int c = pos / 8;
        @(negedge clk);
        if (pos % 8 == 0)
          for (int s = 0; s < NS; s++) inb[f % 4][s][c] = gen(f, s, c);
        for (int s = 0; s < NS; s++) sti[s] = inb[f % 4][s][c][7 - pos % 8];
        fp = (pos == LAST);
        ode = '1;
        if (f == 3 && pos >= 64 && pos < 128) ode[1] = 1'b0;
        if (pos == 0 && f % 2 == 0) begin
          int p = f / 2;
          for (int s = 0; s < NS; s++)
            for (int k = 0; k < NC; k++)
              wq.push_back({8'(s * NC + k), cfg(p, s, k)});
          wq.push_back({8'h80, 10'd0, 2'(p < 2 ? 0 : p - 1)});
        end
        if (f == 5 && pos == LAST) wq.push_front({8'h00, 12'h2A5});
        wr_en = 1'b0;
        if (wq.size() > 0) begin
          logic [19:0] w = wq.pop_front();
          wr_en = 1'b1;
          wr_addr = w[19:12];
          wr_data = w[11:0];
        end
        #1;
        compare(f, pos);
        if (pos == LAST) begin
          act_cfg = sh_cfg;
          rate_act_m = rate_sh_m;
        end
        if (wr_en) begin
          if (wr_addr[7]) rate_sh_m = int'(wr_data[1:0]);
          else            sh_cfg[wr_addr[6:0]] = wr_data;
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    fp = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule